// File: doc/BRIEF.md
# Partition Mapping Valid Register Access Gate

This block holds a 64-bit privileged control register. Its low 32 bits are valid flags, one per virtual partition mapping entry. Its upper 32 bits are reserved. Every access request that selects this register goes through a fixed priority decision. The decision uses the requesting privilege level, two capability flags, a three-bit nested-virtualization control, the presence of the highest level, a lower-level trap enable and two debug-undefined qualifiers.

The decision has four outcomes:
- the access completes directly on the register;
- the access is redirected to a memory offset;
- the access traps to level 2 or level 3 with a fixed syndrome class;
- the access is undefined.

A request is taken on a single valid strobe and its result is registered, so the response appears one cycle later. A write changes the stored flags only when the outcome is a direct completion. A separate combinational helper maps a mapping-entry number to the index of the mapping register that holds it, with four entries per register. The memory access, the exception entry and the mapping lookup are left to surrounding logic.

Top module: `vpart_valid_reg`

## Requirements
- R1: A request is decoded only when its encoding fields are field0=3, field1=4, field2=10, field3=4 and field4=1. Any other encoding gives no response (rsp_valid_o stays 0) and leaves the stored flags unchanged.
- R2: A direct read returns the 32 flags in bits 31:0 and zero in bits 63:32. Write data bits 63:32 are discarded.
- R3: entry_reg_o always equals entry_sel_i shifted right by 2.
- R4: If feat_en_i or hcr_en_i is 0, every access at every level gives code 4 (undefined).
- R5: Every access from level 0 gives code 4.
- R6: At level 1, when nv_ctl_i bits 2 and 0 are both 1, the result is code 2 (memory redirect) with rsp_mem_off_o = 0x938. The stored flags are not changed.
- R7: At level 1, when nv_ctl_i bit 0 is 1 and bit 2 is 0, the result is code 3 (trap) with syndrome 0x18. If el3_en_i and trap_low_i are both 1, the trap goes to level 3, or becomes code 4 when sdd_undef_i is 1. Otherwise the trap goes to level 2.
- R8: At level 1, when nv_ctl_i bit 0 is 0, the result is code 4.
- R9: At level 2, when el3_en_i and trap_low_i are both 1, the result is code 4 if sdd_undef_pri_i is 1. Otherwise it is code 4 if sdd_undef_i is 1. Otherwise it is a code 3 trap to level 3 with syndrome 0x18. When el3_en_i or trap_low_i is 0, the result is code 1 (direct completion).
- R10: At level 3 every access gives code 1.
- R11: The response appears exactly one cycle after the request. A write updates the flags only when its code is 1. Outputs not tied to the code read zero: rdata except on a direct read, the offset except on code 2, and the trap level and syndrome except on code 3.
- R12: Reset clears all 32 flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_f0_i | input | 2 | Encoding field 0 |
| req_f1_i | input | 3 | Encoding field 1 |
| req_f2_i | input | 4 | Encoding field 2 |
| req_f3_i | input | 4 | Encoding field 3 |
| req_f4_i | input | 3 | Encoding field 4 |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 64 | Write data |
| priv_lvl_i | input | 2 | Requesting privilege level 0..3 |
| feat_en_i | input | 1 | Partitioning feature present |
| hcr_en_i | input | 1 | Hypervisor control present |
| nv_ctl_i | input | 3 | Nested-virtualization control |
| el3_en_i | input | 1 | Level 3 implemented |
| trap_low_i | input | 1 | Level 3 traps lower-level accesses |
| sdd_undef_i | input | 1 | Debug-undefined qualifier |
| sdd_undef_pri_i | input | 1 | Priority debug-undefined qualifier |
| entry_sel_i | input | 5 | Mapping entry number |
| entry_reg_o | output | 3 | Mapping register holding that entry |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_code_o | output | 3 | 1 done, 2 memory redirect, 3 trap, 4 undefined |
| rsp_rdata_o | output | 64 | Read data on a direct read |
| rsp_mem_off_o | output | 12 | Memory offset on redirect |
| rsp_trap_lvl_o | output | 2 | Trap target level |
| rsp_syn_o | output | 6 | Trap syndrome class |

## Verification
The decision is swept over all four levels, all eight nested-control values and all sixteen combinations of level-3 presence, trap-lower and the two qualifiers. Both reads and writes are issued, and each result is compared against an independent priority function. This separates the redirect pattern from the plain trap pattern at level 1. It also shows that the priority qualifier at level 2 outranks the plain one, and that a trap is routed to level 2 when the level-3 controls are not both set. After every write a direct read at level 3 shows whether storage moved. That read tells completed writes apart from redirected, trapped and undefined ones, and shows that upper data bits are discarded. Mismatched encodings, cleared capability flags and the entry helper are tried separately.

// File: rtl/vpv_pkg.sv
package vpv_pkg;
  typedef enum logic [2:0] {
    RES_NONE  = 3'd0,
    RES_DONE  = 3'd1,
    RES_MEM   = 3'd2,
    RES_TRAP  = 3'd3,
    RES_UNDEF = 3'd4
  } res_e;

  typedef struct packed {
    res_e       code;
    logic [1:0] lvl;
  } dec_t;

  localparam logic [1:0]  ENC_F0   = 2'b11;
  localparam logic [2:0]  ENC_F1   = 3'b100;
  localparam logic [3:0]  ENC_F2   = 4'b1010;
  localparam logic [3:0]  ENC_F3   = 4'b0100;
  localparam logic [2:0]  ENC_F4   = 3'b001;
  localparam logic [11:0] MEM_OFF  = 12'h938;
  localparam logic [5:0]  TRAP_SYN = 6'h18;
endpackage

// File: rtl/vpv_enc_match.sv
module vpv_enc_match
  import vpv_pkg::*;
(
  input  logic [1:0] f0_i,
  input  logic [2:0] f1_i,
  input  logic [3:0] f2_i,
  input  logic [3:0] f3_i,
  input  logic [2:0] f4_i,
  output logic       hit_o
);
  assign hit_o = (f0_i == ENC_F0) && (f1_i == ENC_F1) && (f2_i == ENC_F2) &&
                 (f3_i == ENC_F3) && (f4_i == ENC_F4);
endmodule

// File: rtl/vpv_decide.sv
module vpv_decide
  import vpv_pkg::*;
(
  input  logic [1:0] lvl_i,
  input  logic       feat_i,
  input  logic       hcr_i,
  input  logic [2:0] nv_i,
  input  logic       el3_i,
  input  logic       tl_i,
  input  logic       sdd_i,
  input  logic       sdd_pri_i,
  output dec_t       dec_o
);
  logic hi_trap;
  assign hi_trap = el3_i && tl_i;

  always_comb begin
    dec_o.code = RES_UNDEF;
    dec_o.lvl  = 2'd0;
    if (feat_i && hcr_i) begin
      unique case (lvl_i)
        2'd0: dec_o.code = RES_UNDEF;
        2'd1: begin
          if (nv_i[2] && nv_i[0]) begin
            dec_o.code = RES_MEM;
          end else if (nv_i[0]) begin
            if (hi_trap) begin
              if (sdd_i) dec_o.code = RES_UNDEF;
              else begin
                dec_o.code = RES_TRAP;
                dec_o.lvl  = 2'd3;
              end
            end else begin
              dec_o.code = RES_TRAP;
              dec_o.lvl  = 2'd2;
            end
          end
        end
        2'd2: begin
          if (hi_trap && sdd_pri_i) dec_o.code = RES_UNDEF;
          else if (hi_trap) begin
            if (sdd_i) dec_o.code = RES_UNDEF;
            else begin
              dec_o.code = RES_TRAP;
              dec_o.lvl  = 2'd3;
            end
          end else begin
            dec_o.code = RES_DONE;
          end
        end
        default: dec_o.code = RES_DONE;
      endcase
    end
  end
endmodule

// File: rtl/vpv_store.sv
module vpv_store #(
  parameter int DATA_W  = 64,
  parameter int NUM_ENT = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [NUM_ENT-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < NUM_ENT) begin : g_flag
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   bit_q <= 1'b0;
        else if (we_i) bit_q <= wdata_i[i];
      end
      assign q_o[i] = bit_q;
    end else begin : g_rsv
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/vpv_entry_idx.sv
module vpv_entry_idx #(
  parameter int NUM_ENT     = 32,
  parameter int ENT_PER_REG = 4,
  localparam int IDX_W      = $clog2(NUM_ENT),
  localparam int SHIFT      = $clog2(ENT_PER_REG),
  localparam int REG_W      = IDX_W - SHIFT
) (
  input  logic [IDX_W-1:0] ent_i,
  output logic [REG_W-1:0] reg_o
);
  assign reg_o = ent_i[IDX_W-1:SHIFT];
endmodule

// File: rtl/vpart_valid_reg.sv
module vpart_valid_reg
  import vpv_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int NUM_ENT     = 32,
  parameter int ENT_PER_REG = 4,
  localparam int IDX_W      = $clog2(NUM_ENT),
  localparam int REG_W      = IDX_W - $clog2(ENT_PER_REG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_f0_i,
  input  logic [2:0]        req_f1_i,
  input  logic [3:0]        req_f2_i,
  input  logic [3:0]        req_f3_i,
  input  logic [2:0]        req_f4_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [1:0]        priv_lvl_i,
  input  logic              feat_en_i,
  input  logic              hcr_en_i,
  input  logic [2:0]        nv_ctl_i,
  input  logic              el3_en_i,
  input  logic              trap_low_i,
  input  logic              sdd_undef_i,
  input  logic              sdd_undef_pri_i,
  input  logic [IDX_W-1:0]  entry_sel_i,
  output logic [REG_W-1:0]  entry_reg_o,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_code_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [11:0]       rsp_mem_off_o,
  output logic [1:0]        rsp_trap_lvl_o,
  output logic [5:0]        rsp_syn_o
);
  logic              hit;
  dec_t              dec;
  logic              take;
  logic              we;
  logic [DATA_W-1:0] store_q;
  logic              unused_rsv;

  assign unused_rsv = ^req_wdata_i[DATA_W-1:NUM_ENT];

  vpv_enc_match u_match (
    .f0_i (req_f0_i),
    .f1_i (req_f1_i),
    .f2_i (req_f2_i),
    .f3_i (req_f3_i),
    .f4_i (req_f4_i),
    .hit_o(hit)
  );

  vpv_decide u_decide (
    .lvl_i    (priv_lvl_i),
    .feat_i   (feat_en_i),
    .hcr_i    (hcr_en_i),
    .nv_i     (nv_ctl_i),
    .el3_i    (el3_en_i),
    .tl_i     (trap_low_i),
    .sdd_i    (sdd_undef_i),
    .sdd_pri_i(sdd_undef_pri_i),
    .dec_o    (dec)
  );

  assign take = req_valid_i && hit;
  assign we   = take && req_write_i && (dec.code == RES_DONE);

  vpv_store #(.DATA_W(DATA_W), .NUM_ENT(NUM_ENT)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .wdata_i(req_wdata_i[NUM_ENT-1:0]),
    .q_o    (store_q)
  );

  vpv_entry_idx #(.NUM_ENT(NUM_ENT), .ENT_PER_REG(ENT_PER_REG)) u_idx (
    .ent_i(entry_sel_i),
    .reg_o(entry_reg_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      rsp_code_o     <= RES_NONE;
      rsp_rdata_o    <= '0;
      rsp_mem_off_o  <= '0;
      rsp_trap_lvl_o <= '0;
      rsp_syn_o      <= '0;
    end else begin
      rsp_valid_o    <= take;
      rsp_code_o     <= take ? dec.code : RES_NONE;
      rsp_rdata_o    <= (take && !req_write_i && dec.code == RES_DONE) ? store_q : '0;
      rsp_mem_off_o  <= (take && dec.code == RES_MEM) ? MEM_OFF : '0;
      rsp_trap_lvl_o <= (take && dec.code == RES_TRAP) ? dec.lvl : '0;
      rsp_syn_o      <= (take && dec.code == RES_TRAP) ? TRAP_SYN : '0;
    end
  end
endmodule

// File: rtl/vpv_chk.sv
module vpv_chk
  import vpv_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [1:0]  req_f0_i,
  input logic [2:0]  req_f1_i,
  input logic [3:0]  req_f2_i,
  input logic [3:0]  req_f3_i,
  input logic [2:0]  req_f4_i,
  input logic [1:0]  priv_lvl_i,
  input logic        feat_en_i,
  input logic        hcr_en_i,
  input logic [4:0]  entry_sel_i,
  input logic [2:0]  entry_reg_o,
  input logic        rsp_valid_o,
  input logic [2:0]  rsp_code_o,
  input logic [63:0] rsp_rdata_o,
  input logic [11:0] rsp_mem_off_o,
  input logic [1:0]  rsp_trap_lvl_o,
  input logic [5:0]  rsp_syn_o,
  input logic [63:0] store_q
);
  logic sel;
  assign sel = req_f0_i == 2'd3 && req_f1_i == 3'd4 && req_f2_i == 4'd10 &&
               req_f3_i == 4'd4 && req_f4_i == 3'd1;

  AST_UNSEL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !sel) |=> !rsp_valid_o); // R1

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_rdata_o[63:32] == 32'd0 && store_q[63:32] == 32'd0)); // R2

  always_comb begin
    if (rst_ni) AST_ENTRY_IDX: assert (entry_reg_o == 3'(entry_sel_i / 5'd4)); // R3
  end

  AST_NOFEAT_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && sel && !(feat_en_i && hcr_en_i)) |=> rsp_code_o == 3'd4); // R4

  AST_EL0_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && sel && priv_lvl_i == 2'd0) |=> rsp_code_o == 3'd4); // R5

  AST_REDIR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o == 3'd2) |-> rsp_mem_off_o == 12'h938); // R6

  AST_TRAP_SYN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o == 3'd3) |-> (rsp_syn_o == 6'h18 && rsp_trap_lvl_o[1])); // R7

  AST_EL3_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && sel && feat_en_i && hcr_en_i && priv_lvl_i == 2'd3) |=> rsp_code_o == 3'd1); // R10

  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i)); // R11

  AST_STORE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && rsp_code_o == 3'd1) |-> store_q == $past(store_q)); // R11
endmodule

bind vpart_valid_reg vpv_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_f0_i      (req_f0_i),
  .req_f1_i      (req_f1_i),
  .req_f2_i      (req_f2_i),
  .req_f3_i      (req_f3_i),
  .req_f4_i      (req_f4_i),
  .priv_lvl_i    (priv_lvl_i),
  .feat_en_i     (feat_en_i),
  .hcr_en_i      (hcr_en_i),
  .entry_sel_i   (entry_sel_i),
  .entry_reg_o   (entry_reg_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_code_o    (rsp_code_o),
  .rsp_rdata_o   (rsp_rdata_o),
  .rsp_mem_off_o (rsp_mem_off_o),
  .rsp_trap_lvl_o(rsp_trap_lvl_o),
  .rsp_syn_o     (rsp_syn_o),
  .store_q       (store_q)
);

// File: tb/vpart_valid_reg_tb.sv
module vpart_valid_reg_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_f0_i = 2'd3;
  logic [2:0]  req_f1_i = 3'd4;
  logic [3:0]  req_f2_i = 4'd10;
  logic [3:0]  req_f3_i = 4'd4;
  logic [2:0]  req_f4_i = 3'd1;
  logic        req_write_i = 1'b0;
  logic [63:0] req_wdata_i = '0;
  logic [1:0]  priv_lvl_i = 2'd3;
  logic        feat_en_i = 1'b1;
  logic        hcr_en_i = 1'b1;
  logic [2:0]  nv_ctl_i = '0;
  logic        el3_en_i = 1'b0;
  logic        trap_low_i = 1'b0;
  logic        sdd_undef_i = 1'b0;
  logic        sdd_undef_pri_i = 1'b0;
  logic [4:0]  entry_sel_i = '0;
  logic [2:0]  entry_reg_o;
  logic        rsp_valid_o;
  logic [2:0]  rsp_code_o;
  logic [63:0] rsp_rdata_o;
  logic [11:0] rsp_mem_off_o;
  logic [1:0]  rsp_trap_lvl_o;
  logic [5:0]  rsp_syn_o;

  int total = 0;
  int bad = 0;
  logic [31:0] shadow = '0;

  logic        g_valid;
  logic [2:0]  g_code;
  logic [63:0] g_rdata;
  logic [11:0] g_off;
  logic [1:0]  g_lvl;
  logic [5:0]  g_syn;

  always #2.5 clk = ~clk;

  vpart_valid_reg u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_f0_i(req_f0_i), .req_f1_i(req_f1_i), .req_f2_i(req_f2_i),
    .req_f3_i(req_f3_i), .req_f4_i(req_f4_i), .req_write_i(req_write_i),
    .req_wdata_i(req_wdata_i), .priv_lvl_i(priv_lvl_i), .feat_en_i(feat_en_i),
    .hcr_en_i(hcr_en_i), .nv_ctl_i(nv_ctl_i), .el3_en_i(el3_en_i),
    .trap_low_i(trap_low_i), .sdd_undef_i(sdd_undef_i),
    .sdd_undef_pri_i(sdd_undef_pri_i), .entry_sel_i(entry_sel_i),
    .entry_reg_o(entry_reg_o), .rsp_valid_o(rsp_valid_o),
    .rsp_code_o(rsp_code_o), .rsp_rdata_o(rsp_rdata_o),
    .rsp_mem_off_o(rsp_mem_off_o), .rsp_trap_lvl_o(rsp_trap_lvl_o),
    .rsp_syn_o(rsp_syn_o)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request, response captured on the following falling edge
  task automatic acc(input logic wr, input logic [63:0] wd);
    @(negedge clk);
    req_valid_i = 1'b1;
    req_write_i = wr;
    req_wdata_i = wd;
    @(negedge clk);
    g_valid = rsp_valid_o; g_code = rsp_code_o; g_rdata = rsp_rdata_o;
    g_off = rsp_mem_off_o; g_lvl = rsp_trap_lvl_o; g_syn = rsp_syn_o;
    req_valid_i = 1'b0;
    req_write_i = 1'b0;
  endtask

  task automatic set_ctl(input logic [1:0] l, input logic f, input logic h, input logic [2:0] nv,
                         input logic e3, input logic tl, input logic sd, input logic pr);
    priv_lvl_i = l; feat_en_i = f; hcr_en_i = h; nv_ctl_i = nv;
    el3_en_i = e3; trap_low_i = tl; sdd_undef_i = sd; sdd_undef_pri_i = pr;
  endtask

  task automatic rd_direct(output logic [63:0] v);
    set_ctl(2'd3, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    acc(1'b0, '0);
    v = g_rdata;
  endtask

  function automatic logic [4:0] ref_dec(input logic [1:0] l, input logic f, input logic h,
      input logic [2:0] nv, input logic e3, input logic tl, input logic sd, input logic pr);
    if (!(f && h)) return {3'd4, 2'd0};
    case (l)
      2'd0: return {3'd4, 2'd0};
      2'd1: begin
        if (nv[2] && nv[0]) return {3'd2, 2'd0};
        if (!nv[0]) return {3'd4, 2'd0};
        if (e3 && tl) return sd ? {3'd4, 2'd0} : {3'd3, 2'd3};
        return {3'd3, 2'd2};
      end
      2'd2: begin
        if (e3 && tl && pr) return {3'd4, 2'd0};
        if (e3 && tl) return sd ? {3'd4, 2'd0} : {3'd3, 2'd3};
        return {3'd1, 2'd0};
      end
      default: return {3'd1, 2'd0};
    endcase
  endfunction

  function automatic string tag(input logic [1:0] l, input logic [2:0] nv);
    if (l == 2'd0) return "R5";
    if (l == 2'd1) return !nv[0] ? "R8" : (nv[2] ? "R6" : "R7");
    if (l == 2'd2) return "R9";
    return "R10";
  endfunction

  task automatic t_reset;
    logic [63:0] v;
    chk(rsp_valid_o == 1'b0, "R12 rsp_valid after reset", 64'(rsp_valid_o), 64'd0);
    rd_direct(v);
    chk(v == 64'd0, "R12 flags after reset", v, 64'd0);
  endtask

  task automatic t_encoding;
    logic [63:0] v;
    set_ctl(2'd3, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) begin
      req_f0_i = (k == 0) ? 2'd2 : 2'd3;
      req_f1_i = (k == 1) ? 3'd0 : 3'd4;
      req_f2_i = (k == 2) ? 4'd11 : 4'd10;
      req_f3_i = (k == 3) ? 4'd5 : 4'd4;
      req_f4_i = (k == 4) ? 3'd0 : 3'd1;
      acc(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
      chk(g_valid == 1'b0, "R1 no response on other encoding", 64'(g_valid), 64'd0);
    end
    req_f0_i = 2'd3; req_f1_i = 3'd4; req_f2_i = 4'd10; req_f3_i = 4'd4; req_f4_i = 3'd1;
    rd_direct(v);
    chk(v == {32'd0, shadow}, "R1 flags unchanged", v, {32'd0, shadow});
  endtask

  task automatic t_reserved;
    logic [63:0] v;
    set_ctl(2'd3, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    acc(1'b1, 64'hDEAD_BEEF_A5C3_0F69);
    chk(g_valid && g_code == 3'd1 && g_rdata == 64'd0, "R11 write response", {61'd0, g_code}, 64'd1);
    shadow = 32'hA5C3_0F69;
    rd_direct(v);
    chk(v == {32'd0, shadow}, "R2 upper bits zero", v, {32'd0, shadow});
    chk(g_off == 0 && g_lvl == 0 && g_syn == 0, "R11 idle fields on direct read",
        {44'd0, g_off, g_lvl, g_syn}, 64'd0);
  endtask

  task automatic t_entry_idx;
    for (int m = 0; m < 32; m++) begin
      entry_sel_i = 5'(m);
      #1;
      chk(entry_reg_o == 3'(m >> 2), "R3 entry register index", 64'(entry_reg_o), 64'(m >> 2));
    end
  endtask

  task automatic t_nofeat;
    logic [63:0] v;
    for (int fh = 0; fh < 3; fh++) begin
      for (int l = 0; l < 4; l++) begin
        set_ctl(2'(l), fh[0], fh[1], 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        acc(1'b1, 64'h0000_0000_1234_5678);
        chk(g_valid && g_code == 3'd4, "R4 undefined without feature", {61'd0, g_code}, 64'd4);
      end
    end
    rd_direct(v);
    chk(v == {32'd0, shadow}, "R4 flags unchanged", v, {32'd0, shadow});
  endtask

  task automatic t_sweep;
    logic [63:0] v;
    logic [4:0]  e;
    logic [63:0] wd;
    for (int l = 0; l < 4; l++) begin
      for (int nv = 0; nv < 8; nv++) begin
        for (int c = 0; c < 16; c++) begin
          e  = ref_dec(2'(l), 1'b1, 1'b1, 3'(nv), c[3], c[2], c[1], c[0]);
          wd = {32'hFFFF_0000 ^ 32'(c), 32'(l * 131071 + nv * 4099 + c * 977 + 32'h5A5A_0000)};
          set_ctl(2'(l), 1'b1, 1'b1, 3'(nv), c[3], c[2], c[1], c[0]);
          acc(1'b0, '0);
          chk(g_valid && g_code == e[4:2], {tag(2'(l), 3'(nv)), " read code"}, {61'd0, g_code}, {61'd0, e[4:2]});
          chk(g_rdata == ((e[4:2] == 3'd1) ? {32'd0, shadow} : 64'd0), "R11 read data", g_rdata,
              (e[4:2] == 3'd1) ? {32'd0, shadow} : 64'd0);
          acc(1'b1, wd);
          chk(g_code == e[4:2], {tag(2'(l), 3'(nv)), " write code"}, {61'd0, g_code}, {61'd0, e[4:2]});
          chk(g_lvl == e[1:0] && g_syn == ((e[4:2] == 3'd3) ? 6'h18 : 6'h0),
              {tag(2'(l), 3'(nv)), " trap level/syndrome"}, {56'd0, g_lvl, g_syn},
              {56'd0, e[1:0], (e[4:2] == 3'd3) ? 6'h18 : 6'h0});
          chk(g_off == ((e[4:2] == 3'd2) ? 12'h938 : 12'h0), {tag(2'(l), 3'(nv)), " offset"},
              64'(g_off), (e[4:2] == 3'd2) ? 64'h938 : 64'h0);
          if (e[4:2] == 3'd1) shadow = wd[31:0];
          rd_direct(v);
          chk(v == {32'd0, shadow}, "R11 store after write", v, {32'd0, shadow});
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_encoding();
    t_entry_idx();
    t_nofeat();
    t_sweep();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule